// File: doc/BRIEF.md
# Character Display Memory Access Port

This block is the processor-facing side of a character-display controller. The processor reaches a small bank of internal registers indirectly. It first writes a register number to an index port, then reads or writes the chosen register through a register-data port. A third CPU address, the display-data port, moves one byte to or from display memory at the current update address. Every access to that port advances the address by one, so a whole line of text can be streamed without reloading the pointer.

The update address is 14 bits wide and is split over two registers: a high register that keeps six bits and a low register that keeps eight. A light-pen strobe from the screen is synchronised to the clock. On its rising edge the block captures the current refresh address plus one into a read-only pen address pair and raises a status flag. Software reads that flag through the index port. The display RAM sits outside the block behind a plain address, write-data, read-data and write-strobe bus.

Top module: `crtc_mem_port`

## Requirements
- R1: Synchronous active-high reset clears the register index, the update address, the captured pen address and the pen status flag.
- R2: Port select 0 is the index port (a write loads the low 5 bits as the register number, a read returns status), 1 is the register-data port, 2 is the display-data port, and 3 selects nothing.
- R3: Register number 0x12 is the update-address high register; a write keeps only data bits 5:0, reads return them with bits 7:6 zero, and the low byte is left unchanged.
- R4: Register number 0x13 is the update-address low register, a full 8-bit read/write field.
- R5: A display-data write drives mem_we high for exactly that one cycle, with mem_addr equal to the pre-increment update address and mem_wdata equal to the CPU byte; mem_addr shows the address plus one from the next cycle.
- R6: A display-data read returns mem_rdata in the same cycle and also advances the update address by one.
- R7: An increment carries from low byte 0xFF into the high register, and 0x3FFF wraps to 0x0000.
- R8: A rising edge of the pen strobe, after a two-flop synchroniser, captures refresh_addr + 1 three clock edges after the strobe is first sampled high; register 0x10 returns capture bits 13:8 (bits 7:6 zero) and 0x11 returns bits 7:0. For a 40-column screen the cell at row r, column c (refresh address r*40+c) reads back r*40+c+1.
- R9: Reading the index port returns the pen flag in bit 6, with all other bits zero. The flag is set by a capture and cleared by a status read, and a capture in the same cycle wins.
- R10: Writes to registers 0x10, 0x11 or any unassigned number, and writes to port 3, change no state; unassigned numbers and port 3 read as zero.
- R11: A strobe held high captures only once; refresh changes while it stays high are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_port | input | 2 | CPU port select (0 index/status, 1 register data, 2 display data, 3 none) |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for the selected port |
| refresh_addr | input | 14 | Current refresh address from the raster timing logic |
| pen_strobe | input | 1 | Asynchronous light-pen strobe |
| mem_addr | output | 14 | Display RAM address (update address) |
| mem_wdata | output | 8 | Display RAM write data |
| mem_rdata | input | 8 | Display RAM read data |
| mem_we | output | 1 | Display RAM write strobe |

## Verification
A wrong update address shows on mem_addr in the very cycle after the access that produced it, because the pointer drives the RAM bus directly; the bench compares it with its own model on every clock. A wrong register number, pen capture or flag stays hidden until software reads it, so the bench reads back each register right after changing it. It also reads the pen pair a few cycles after each strobe edge, so a stale or early capture is caught within about five cycles.

// File: rtl/crtc_port_pkg.sv
package crtc_port_pkg;

   typedef enum logic [1:0] {
      PORT_INDEX   = 2'd0,
      PORT_REGDATA = 2'd1,
      PORT_DISPLAY = 2'd2,
      PORT_NONE    = 2'd3
   } port_sel_e;

   localparam logic [4:0] IDX_PEN_HI = 5'h10;
   localparam logic [4:0] IDX_PEN_LO = 5'h11;
   localparam logic [4:0] IDX_UPD_HI = 5'h12;
   localparam logic [4:0] IDX_UPD_LO = 5'h13;

   localparam int STAT_PEN_BIT = 6;

endpackage

// File: rtl/crtc_update_addr.sv
module crtc_update_addr #(
   parameter int AW = 14,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ld_hi,
   input  logic          ld_lo,
   input  logic          step,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] addr
);
   localparam int HW = AW - DW;

   if (HW < 1 || HW > DW) begin : g_bad_width
      $error("crtc_update_addr: AW must lie in DW+1 .. 2*DW");
   end

   logic [AW-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
      end else if (step) begin
         addr_q <= addr_q + AW'(1);
      end else begin
         if (ld_hi) addr_q[AW-1:DW] <= wdata[HW-1:0];
         if (ld_lo) addr_q[DW-1:0]  <= wdata;
      end
   end

   assign addr = addr_q;

   // R5 R6 R7
   step_inc_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> addr_q == $past(addr_q) + AW'(1));

   // R3
   hi_load_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_hi && !ld_lo && !step) |=> addr_q[DW-1:0] == $past(addr_q[DW-1:0]));

   // R4
   lo_load_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
      (ld_lo && !ld_hi && !step) |=> addr_q[AW-1:DW] == $past(addr_q[AW-1:DW]));

endmodule

// File: rtl/crtc_pen_capture.sv
module crtc_pen_capture #(
   parameter int AW          = 14,
   parameter int SYNC_STAGES = 2,
   parameter int PEN_ADJ     = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          strobe,
   input  logic [AW-1:0] refresh_addr,
   input  logic          flag_clr,
   output logic [AW-1:0] pen_addr,
   output logic          pen_flag
);
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("crtc_pen_capture: SYNC_STAGES must be 1..4");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;
   logic                   rise;
   logic [AW-1:0]          pen_q;
   logic                   flag_q;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
         if (rst) sync_q <= '0;
         else     sync_q <= strobe;
      end
   end else begin : g_syncn
      always_ff @(posedge clk) begin
         if (rst) sync_q <= '0;
         else     sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];
   assign rise   = synced & ~prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= 1'b0;
         pen_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         prev_q <= synced;
         if (rise) begin
            pen_q  <= refresh_addr + AW'(PEN_ADJ);
            flag_q <= 1'b1;
         end else if (flag_clr) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign pen_addr = pen_q;
   assign pen_flag = flag_q;

   // R9
   flag_set_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> flag_q);

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_clr && !rise) |=> !flag_q);

   // R8
   capture_value_chk: assert property (@(posedge clk) disable iff (rst)
      rise |=> pen_q == $past(refresh_addr) + AW'(PEN_ADJ));

   // R11
   held_no_recapture_chk: assert property (@(posedge clk) disable iff (rst)
      (synced && prev_q) |=> $stable(pen_q));

endmodule

// File: rtl/crtc_mem_port.sv
module crtc_mem_port
   import crtc_port_pkg::*;
#(
   parameter int AW          = 14,
   parameter int DW          = 8,
   parameter int IDX_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int PEN_ADJ     = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    cpu_port,
   input  logic          cpu_wr,
   input  logic          cpu_rd,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   input  logic [AW-1:0] refresh_addr,
   input  logic          pen_strobe,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_we
);
   localparam int HW = AW - DW;

   if (IDX_W < 5 || IDX_W > DW) begin : g_bad_idx
      $error("crtc_mem_port: IDX_W must be 5..DW");
   end
   if (STAT_PEN_BIT >= DW) begin : g_bad_stat
      $error("crtc_mem_port: status bit outside data width");
   end

   port_sel_e      sel;
   logic [IDX_W-1:0] idx_q;
   logic           wr_index, wr_reg, disp_acc, stat_rd;
   logic [AW-1:0]  upd_addr;
   logic [AW-1:0]  pen_addr;
   logic           pen_flag;

   assign sel      = port_sel_e'(cpu_port);
   assign wr_index = cpu_wr && (sel == PORT_INDEX);
   assign wr_reg   = cpu_wr && (sel == PORT_REGDATA);
   assign disp_acc = (cpu_wr || cpu_rd) && (sel == PORT_DISPLAY);
   assign stat_rd  = cpu_rd && (sel == PORT_INDEX);

   always_ff @(posedge clk) begin
      if (rst)           idx_q <= '0;
      else if (wr_index) idx_q <= cpu_wdata[IDX_W-1:0];
   end

   crtc_update_addr #(
      .AW (AW),
      .DW (DW)
   ) u_upd (
      .clk   (clk),
      .rst   (rst),
      .ld_hi (wr_reg && (idx_q == IDX_W'(IDX_UPD_HI))),
      .ld_lo (wr_reg && (idx_q == IDX_W'(IDX_UPD_LO))),
      .step  (disp_acc),
      .wdata (cpu_wdata),
      .addr  (upd_addr)
   );

   crtc_pen_capture #(
      .AW          (AW),
      .SYNC_STAGES (SYNC_STAGES),
      .PEN_ADJ     (PEN_ADJ)
   ) u_pen (
      .clk          (clk),
      .rst          (rst),
      .strobe       (pen_strobe),
      .refresh_addr (refresh_addr),
      .flag_clr     (stat_rd),
      .pen_addr     (pen_addr),
      .pen_flag     (pen_flag)
   );

   always_comb begin
      cpu_rdata = '0;
      unique case (sel)
         PORT_INDEX:   cpu_rdata[STAT_PEN_BIT] = pen_flag;
         PORT_REGDATA: begin
            if (idx_q == IDX_W'(IDX_PEN_HI))      cpu_rdata = DW'(pen_addr[AW-1:DW]);
            else if (idx_q == IDX_W'(IDX_PEN_LO)) cpu_rdata = pen_addr[DW-1:0];
            else if (idx_q == IDX_W'(IDX_UPD_HI)) cpu_rdata = DW'(upd_addr[AW-1:DW]);
            else if (idx_q == IDX_W'(IDX_UPD_LO)) cpu_rdata = upd_addr[DW-1:0];
         end
         PORT_DISPLAY: cpu_rdata = mem_rdata;
         default:      cpu_rdata = '0;
      endcase
   end

   assign mem_addr  = upd_addr;
   assign mem_wdata = cpu_wdata;
   assign mem_we    = cpu_wr && (sel == PORT_DISPLAY);

   // R5
   mem_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> mem_addr == $past(mem_addr) + AW'(1));

   // R10
   idle_port_no_change_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_port == 2'd3) |=> $stable(mem_addr) && $stable(idx_q));

   // R3
   high_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cpu_port == 2'd1 && idx_q == IDX_W'(IDX_UPD_HI)) |-> cpu_rdata[DW-1:HW] == '0);

endmodule

// File: tb/crtc_mem_port_test.sv
module crtc_mem_port_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  cpu_port = 2'd3;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [7:0]  cpu_rdata;
   logic [13:0] refresh_addr = 14'd0;
   logic        pen_strobe = 1'b0;
   logic [13:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'h00;
   logic        mem_we;

   always #2.5 clk = ~clk;

   crtc_mem_port uut (
      .clk(clk), .rst(rst), .cpu_port(cpu_port), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .refresh_addr(refresh_addr),
      .pen_strobe(pen_strobe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_we(mem_we)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   int m_idx = 0, m_upd = 0, m_pen = 0, m_flag = 0;
   int h0 = 0, h1 = 0, h2 = 0;

   logic [7:0]  rdv;
   logic        smp_we;
   logic [13:0] smp_addr;
   logic [7:0]  smp_wd;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_read(input int p);
      case (p)
         0: return m_flag << 6;
         1: case (m_idx)
               16: return (m_pen >> 8) & 63;
               17: return m_pen & 255;
               18: return (m_upd >> 8) & 63;
               19: return m_upd & 255;
               default: return 0;
            endcase
         2: return int'(mem_rdata);
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_idx = 0; m_upd = 0; m_pen = 0; m_flag = 0; h0 = 0; h1 = 0; h2 = 0;
      end else begin
         int rise;
         rise = (h1 == 1 && h2 == 0) ? 1 : 0;
         if (rise == 1) begin
            m_pen  = (int'(refresh_addr) + 1) % 16384;
            m_flag = 1;
         end else if (cpu_rd && cpu_port == 0) begin
            m_flag = 0;
         end
         if (cpu_wr && cpu_port == 0) m_idx = cpu_wdata & 31;
         if (cpu_port == 2 && (cpu_wr || cpu_rd)) begin
            m_upd = (m_upd + 1) % 16384;
         end else if (cpu_wr && cpu_port == 1) begin
            if (m_idx == 18) m_upd = (m_upd & 255) | ((cpu_wdata & 63) << 8);
            if (m_idx == 19) m_upd = (m_upd & 16128) | cpu_wdata;
         end
         h2 = h1; h1 = h0; h0 = pen_strobe ? 1 : 0;
      end
   end

   // per-clock comparison against the model, away from the edge
   always @(negedge clk) begin
      #2;
      if (!rst && !done) begin
         chk("R5 mem_addr model", int'(mem_addr), m_upd);
         chk("R5 mem_we model", int'(mem_we), (cpu_wr && cpu_port == 2) ? 1 : 0);
         if (cpu_rd) chk("R2 rdata model", int'(cpu_rdata), model_read(int'(cpu_port)));
      end
   end

   task automatic op(input logic [1:0] p, input logic w, input logic r, input logic [7:0] d);
      @(negedge clk);
      cpu_port = p; cpu_wr = w; cpu_rd = r; cpu_wdata = d;
      #1;
      rdv = cpu_rdata; smp_we = mem_we; smp_addr = mem_addr; smp_wd = mem_wdata;
      @(posedge clk);
      #1;
      cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_port = 2'd3;
   endtask

   task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
      op(2'd0, 1'b1, 1'b0, idx);
      op(2'd1, 1'b1, 1'b0, val);
   endtask

   task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
      op(2'd0, 1'b1, 1'b0, idx);
      op(2'd1, 1'b0, 1'b1, 8'h00);
      v = rdv;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_up();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;

      // R1 reset state
      op(2'd0, 1'b0, 1'b1, 8'h00);
      chk("R1 status after reset", int'(rdv), 0);
      chk("R1 mem_addr after reset", int'(mem_addr), 0);
      get_reg(8'h10, v); chk("R1 pen hi after reset", int'(v), 0);
      get_reg(8'h11, v); chk("R1 pen lo after reset", int'(v), 0);

      // R3 R4 update address loads; index upper bits ignored (R2)
      set_reg(8'hF2, 8'hFF);
      get_reg(8'h12, v); chk("R3 high keeps 6 bits", int'(v), 8'h3F);
      set_reg(8'h13, 8'hFE);
      get_reg(8'h13, v); chk("R4 low byte", int'(v), 8'hFE);
      chk("R4 mem_addr shows pointer", int'(mem_addr), 14'h3FFE);

      // R5 display write
      op(2'd2, 1'b1, 1'b0, 8'hA5);
      chk("R5 we during write", int'(smp_we), 1);
      chk("R5 pre-increment addr", int'(smp_addr), 14'h3FFE);
      chk("R5 write data", int'(smp_wd), 8'hA5);
      @(negedge clk); #1;
      chk("R5 we one cycle", int'(mem_we), 0);
      chk("R5 addr advanced", int'(mem_addr), 14'h3FFF);

      // R7 wrap
      op(2'd2, 1'b1, 1'b0, 8'h3C);
      chk("R7 wrap source addr", int'(smp_addr), 14'h3FFF);
      @(negedge clk); #1;
      chk("R7 wrap to zero", int'(mem_addr), 0);

      // R6 display read and R7 carry
      set_reg(8'h12, 8'h00);
      set_reg(8'h13, 8'hFF);
      mem_rdata = 8'h5C;
      op(2'd2, 1'b0, 1'b1, 8'h00);
      chk("R6 read data", int'(rdv), 8'h5C);
      chk("R6 no write on read", int'(smp_we), 0);
      get_reg(8'h12, v); chk("R7 carry into high", int'(v), 8'h01);
      get_reg(8'h13, v); chk("R7 low rolls to zero", int'(v), 8'h00);

      // R10 read-only, unassigned and idle port
      set_reg(8'h10, 8'h33);
      get_reg(8'h10, v); chk("R10 pen hi unwritable", int'(v), 0);
      set_reg(8'h05, 8'h77);
      get_reg(8'h05, v); chk("R10 unassigned reads zero", int'(v), 0);
      op(2'd3, 1'b1, 1'b0, 8'h99);
      chk("R10 idle port no strobe", int'(smp_we), 0);
      get_reg(8'h13, v); chk("R10 pointer untouched", int'(v), 8'h00);

      // R8 capture row 3 column 7 -> 127 + 1
      refresh_addr = 14'd127;
      @(negedge clk); pen_strobe = 1'b1;
      idle(5);
      get_reg(8'h10, v); chk("R8 pen hi", int'(v), 8'h00);
      get_reg(8'h11, v); chk("R8 pen lo", int'(v), 8'h80);
      // R11 held strobe
      refresh_addr = 14'd500;
      idle(5);
      get_reg(8'h11, v); chk("R11 no recapture", int'(v), 8'h80);
      // R9 flag read and clear
      op(2'd0, 1'b0, 1'b1, 8'h00); chk("R9 flag set", int'(rdv), 8'h40);
      op(2'd0, 1'b0, 1'b1, 8'h00); chk("R9 flag cleared", int'(rdv), 8'h00);

      // R8 second capture at row 24 column 39 -> 1000
      @(negedge clk); pen_strobe = 1'b0;
      idle(4);
      refresh_addr = 14'd999;
      @(negedge clk); pen_strobe = 1'b1;
      idle(5);
      get_reg(8'h10, v); chk("R8 pen hi corner", int'(v), 8'h03);
      get_reg(8'h11, v); chk("R8 pen lo corner", int'(v), 8'hE8);
      op(2'd0, 1'b0, 1'b1, 8'h00); chk("R9 flag set again", int'(rdv), 8'h40);
      @(negedge clk); pen_strobe = 1'b0;

      // R1 reset mid-run
      @(negedge clk); rst = 1'b1;
      idle(2);
      rst = 1'b0;
      idle(1);
      chk("R1 pointer cleared", int'(mem_addr), 0);
      op(2'd1, 1'b0, 1'b1, 8'h00); chk("R1 index cleared", int'(rdv), 0);
      get_reg(8'h11, v); chk("R1 pen cleared", int'(v), 0);

      idle(2);
      finish_up();
   end
endmodule